// File: doc/BRIEF.md
# NOR Array Program and Erase Controller

This controller sits between a command sequencer and a synchronous, byte-wide memory array that lives outside the block. It accepts two kinds of request: a single-byte program and a region erase. Each request carries an address. An erase also carries a size code.

In normal mode a program can only clear bits. The controller reads the stored byte, ANDs the new data into it and writes the result back. A selectable EEPROM mode writes the new byte as given. An erase aligns its start address down to the region size and fills the region with 0xFF, one byte per clock, ascending. The busy output stays high for the whole walk.

The controller also raises three flags. An erase is dropped when write enable is low. An erase size the device lacks raises a flag, but the erase still runs. A program without write enable raises a protection flag, but the write still happens.

Top module: `nor_pe_ctrl`

## Requirements
- R1: In normal mode, a program accepted at clock edge E0 reads the array at E0 and writes (old AND new) to the same address at E1. `busy` is high for exactly the one cycle between E0 and E1.
- R2: With `eeprom_mode` high at acceptance, a program writes the new byte unchanged, so 0 bits may become 1.
- R3: A normal-mode program that would turn any stored 0 bit into 1 sets the sticky `warn` output at its write edge. EEPROM-mode programs never set it. `warn` stays high until `warn_clr` is sampled high, and the clear wins over a same-cycle set.
- R4: A program accepted while `wr_en` is low pulses `prot_err` high for one cycle, in the cycle after acceptance, and the write is still applied.
- R5: Erase codes select the region: 8'h20 and 8'h21 select SMALL_BYTES (4096), 8'h52 selects MID_BYTES (32768), 8'hD8 and 8'hDC select SECTOR_BYTES (16384), and 8'hC7 selects the whole array (SECTOR_BYTES*SECTOR_COUNT = 65536). The start is `req_addr` with the low log2(size) bits cleared, and every byte of the region becomes 8'hFF.
- R6: An accepted erase writes one byte per clock at consecutive ascending addresses, starting in the cycle after acceptance. `busy` is high for exactly region-size cycles.
- R7: An erase request seen while `wr_en` is low is dropped: there are no array writes and `busy` stays low.
- R8: An erase whose size has its capability parameter clear (CAP_MID=0 by default, so code 8'h52) pulses `cap_err` for one cycle after the request, and the erase still runs. Enabled sizes never raise `cap_err`.
- R9: Requests sampled while `busy` is high are ignored: no array read and no change to the array. A simultaneous erase request takes priority over a program request.
- R10: An erase request with any code other than those in R5 is ignored: there are no writes and `busy` stays low.
- R11: After reset, `busy`, `prot_err`, `cap_err` and `warn` are low, and no array read or write is issued until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_req | input | 1 | Program one byte request |
| erase_req | input | 1 | Erase region request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_data | input | 8 | Byte to program |
| erase_code | input | 8 | Erase size code |
| wr_en | input | 1 | Write enable from the sequencer |
| eeprom_mode | input | 1 | Overwrite instead of AND on program |
| warn_clr | input | 1 | Clears the sticky warning |
| busy | output | 1 | Operation in progress, requests ignored |
| prot_err | output | 1 | One-cycle pulse: program without write enable |
| cap_err | output | 1 | One-cycle pulse: unsupported erase size requested |
| warn | output | 1 | Sticky: program attempted a 0-to-1 bit change |
| mem_addr | output | ADDR_W | Array address |
| mem_rd_en | output | 1 | Array read strobe, data returns next cycle |
| mem_rdata | input | 8 | Array read data |
| mem_wr_en | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |

## Verification
Programs are applied as a sequence to the same few addresses. The sequence alternates between normal and EEPROM mode, so that the stored result tells AND semantics apart from overwrite semantics. It also shows that a 0-to-1 attempt sets the warning only in normal mode, and that the warning then sticks until it is cleared.

Erases are issued with start addresses that are not aligned, and the bench first programs marker bytes just inside and just outside each region. The first and last erased bytes show the alignment, and the untouched neighbours show the region size. The write count and the busy length must both equal the region size.

Further patterns cover an erase without write enable, an unknown erase code, a disabled erase size, and a program request injected while an erase is running. Each of these separates dropping a request from flagging it.

// File: rtl/nor_pe_pkg.sv
package nor_pe_pkg;

    localparam logic [7:0] CODE_SMALL_A = 8'h20;
    localparam logic [7:0] CODE_SMALL_B = 8'h21;
    localparam logic [7:0] CODE_MID     = 8'h52;
    localparam logic [7:0] CODE_SECT_A  = 8'hD8;
    localparam logic [7:0] CODE_SECT_B  = 8'hDC;
    localparam logic [7:0] CODE_ALL     = 8'hC7;
    localparam logic [7:0] ERASED_BYTE  = 8'hFF;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SMALL,
        RG_MID,
        RG_SECTOR,
        RG_ALL
    } region_e;

    typedef struct packed {
        logic [7:0] wdata;
        logic       zero_to_one;
    } merge_t;

    function automatic region_e code_to_region(input logic [7:0] code);
        region_e r;
        case (code)
            CODE_SMALL_A, CODE_SMALL_B: r = RG_SMALL;
            CODE_MID:                   r = RG_MID;
            CODE_SECT_A, CODE_SECT_B:   r = RG_SECTOR;
            CODE_ALL:                   r = RG_ALL;
            default:                    r = RG_NONE;
        endcase
        return r;
    endfunction

    function automatic merge_t merge_byte(input logic [7:0] old_b,
                                          input logic [7:0] new_b,
                                          input logic       overwrite);
        merge_t m;
        m.wdata       = overwrite ? new_b : (old_b & new_b);
        m.zero_to_one = !overwrite && (|(~old_b & new_b));
        return m;
    endfunction

endpackage

// File: rtl/nor_pe_region.sv
module nor_pe_region
    import nor_pe_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int SMALL_BYTES  = 4096,
    parameter int MID_BYTES    = 32768,
    parameter int SECTOR_BYTES = 16384,
    parameter bit CAP_SMALL    = 1'b1,
    parameter bit CAP_MID      = 1'b0
) (
    input  logic [7:0]        code,
    input  logic [ADDR_W-1:0] addr,
    output logic              valid,
    output logic              cap_miss,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] last
);
    localparam logic [ADDR_W-1:0] SMALL_M1 = ADDR_W'(SMALL_BYTES - 1);
    localparam logic [ADDR_W-1:0] MID_M1   = ADDR_W'(MID_BYTES - 1);
    localparam logic [ADDR_W-1:0] SECT_M1  = ADDR_W'(SECTOR_BYTES - 1);

    logic [ADDR_W-1:0] span_m1;

    always_comb begin
        valid    = 1'b1;
        cap_miss = 1'b0;
        span_m1  = '0;
        case (code_to_region(code))
            RG_SMALL: begin
                span_m1  = SMALL_M1;
                cap_miss = !CAP_SMALL;
            end
            RG_MID: begin
                span_m1  = MID_M1;
                cap_miss = !CAP_MID;
            end
            RG_SECTOR: span_m1 = SECT_M1;
            RG_ALL:    span_m1 = '1;
            default:   valid   = 1'b0;
        endcase
    end

    assign base = addr & ~span_m1;
    assign last = addr | span_m1;

endmodule

// File: rtl/nor_pe_merge.sv
module nor_pe_merge
    import nor_pe_pkg::*;
(
    input  logic [7:0] old_b,
    input  logic [7:0] new_b,
    input  logic       overwrite,
    output logic [7:0] wdata,
    output logic       zero_to_one
);
    merge_t m;

    always_comb m = merge_byte(old_b, new_b, overwrite);

    assign wdata       = m.wdata;
    assign zero_to_one = m.zero_to_one;

endmodule

// File: rtl/nor_pe_walker.sv
module nor_pe_walker #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] last,
    output logic              active,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ptr    <= '0;
            last_q <= '0;
        end else if (start) begin
            active <= 1'b1;
            ptr    <= base;
            last_q <= last;
        end else if (active) begin
            if (ptr == last_q) begin
                active <= 1'b0;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nor_pe_ctrl.sv
module nor_pe_ctrl
    import nor_pe_pkg::*;
#(
    parameter int SMALL_BYTES  = 4096,
    parameter int MID_BYTES    = 32768,
    parameter int SECTOR_BYTES = 16384,
    parameter int SECTOR_COUNT = 4,
    parameter bit CAP_SMALL    = 1'b1,
    parameter bit CAP_MID      = 1'b0,
    localparam int ARRAY_BYTES = SECTOR_BYTES * SECTOR_COUNT,
    localparam int ADDR_W      = $clog2(ARRAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_req,
    input  logic              erase_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic [7:0]        erase_code,
    input  logic              wr_en,
    input  logic              eeprom_mode,
    input  logic              warn_clr,
    output logic              busy,
    output logic              prot_err,
    output logic              cap_err,
    output logic              warn,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata
);
    logic              rg_valid;
    logic              rg_cap_miss;
    logic [ADDR_W-1:0] rg_base;
    logic [ADDR_W-1:0] rg_last;
    logic              erase_go;
    logic              prog_go;
    logic              walk_active;
    logic [ADDR_W-1:0] walk_ptr;
    logic              prog_pend;
    logic [ADDR_W-1:0] prog_addr;
    logic [7:0]        prog_data;
    logic              prog_over;
    logic [7:0]        merged;
    logic              merged_z2o;
    logic              idle;

    nor_pe_region #(
        .ADDR_W      (ADDR_W),
        .SMALL_BYTES (SMALL_BYTES),
        .MID_BYTES   (MID_BYTES),
        .SECTOR_BYTES(SECTOR_BYTES),
        .CAP_SMALL   (CAP_SMALL),
        .CAP_MID     (CAP_MID)
    ) u_region (
        .code    (erase_code),
        .addr    (req_addr),
        .valid   (rg_valid),
        .cap_miss(rg_cap_miss),
        .base    (rg_base),
        .last    (rg_last)
    );

    assign idle     = !busy;
    assign erase_go = erase_req && idle && rg_valid && wr_en;
    assign prog_go  = prog_req && idle && !erase_req;

    nor_pe_walker #(.ADDR_W(ADDR_W)) u_walker (
        .clk   (clk),
        .rst   (rst),
        .start (erase_go),
        .base  (rg_base),
        .last  (rg_last),
        .active(walk_active),
        .ptr   (walk_ptr)
    );

    nor_pe_merge u_merge (
        .old_b      (mem_rdata),
        .new_b      (prog_data),
        .overwrite  (prog_over),
        .wdata      (merged),
        .zero_to_one(merged_z2o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_pend <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
            prog_over <= 1'b0;
            prot_err  <= 1'b0;
            cap_err   <= 1'b0;
            warn      <= 1'b0;
        end else begin
            prog_pend <= prog_go;
            if (prog_go) begin
                prog_addr <= req_addr;
                prog_data <= req_data;
                prog_over <= eeprom_mode;
            end
            prot_err <= prog_go && !wr_en;
            cap_err  <= erase_req && idle && rg_valid && rg_cap_miss;
            if (warn_clr) begin
                warn <= 1'b0;
            end else if (prog_pend && merged_z2o) begin
                warn <= 1'b1;
            end
        end
    end

    assign busy      = walk_active || prog_pend;
    assign mem_rd_en = prog_go;
    assign mem_wr_en = walk_active || prog_pend;
    assign mem_wdata = walk_active ? ERASED_BYTE : merged;

    always_comb begin
        if (walk_active) begin
            mem_addr = walk_ptr;
        end else if (prog_pend) begin
            mem_addr = prog_addr;
        end else begin
            mem_addr = req_addr;
        end
    end

endmodule

// File: rtl/nor_pe_ctrl_chk.sv
module nor_pe_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              prot_err,
    input logic              cap_err,
    input logic              warn,
    input logic              warn_clr,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_addr
);
    p_quiet_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !prot_err && !cap_err && !warn));

    p_no_read_when_busy_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !mem_rd_en);

    p_write_only_busy_r7: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> busy);

    p_walk_ascending_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && $past(mem_wr_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    p_prot_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        prot_err |=> !prot_err);

    p_cap_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        cap_err |=> !cap_err);

    p_warn_cleared_r3: assert property (@(posedge clk) disable iff (rst)
        warn_clr |=> !warn);

    p_warn_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (warn && !warn_clr) |=> warn);

endmodule

bind nor_pe_ctrl nor_pe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .prot_err (prot_err),
    .cap_err  (cap_err),
    .warn     (warn),
    .warn_clr (warn_clr),
    .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en),
    .mem_addr (mem_addr)
);

// File: tb/nor_pe_ctrl_test.sv
`timescale 1ns/1ps
module nor_pe_ctrl_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prog_req = 1'b0;
    logic          erase_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic [7:0]    erase_code = '0;
    logic          wr_en = 1'b1;
    logic          eeprom_mode = 1'b0;
    logic          warn_clr = 1'b0;
    logic          busy, prot_err, cap_err, warn;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_en, mem_wr_en;
    logic [7:0]    mem_rdata = 8'h00;
    logic [7:0]    mem_wdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nor_pe_ctrl uut (
        .clk(clk), .rst(rst), .prog_req(prog_req), .erase_req(erase_req),
        .req_addr(req_addr), .req_data(req_data), .erase_code(erase_code),
        .wr_en(wr_en), .eeprom_mode(eeprom_mode), .warn_clr(warn_clr),
        .busy(busy), .prot_err(prot_err), .cap_err(cap_err), .warn(warn),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
    );

    // array model: erased at power-up, synchronous read-first
    logic [7:0]    mem [int];
    int            wr_cnt = 0;
    int            order_bad = 0;
    int            any_access = 0;
    logic          prev_wr = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    function automatic logic [7:0] rd(input int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en || mem_wr_en) any_access = any_access + 1;
        if (mem_rd_en) mem_rdata <= rd(int'(mem_addr));
        if (mem_wr_en) begin
            if (prev_wr && mem_addr != AW'(prev_addr + 1'b1)) order_bad = order_bad + 1;
            mem[int'(mem_addr)] = mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
        prev_wr   = mem_wr_en;
        prev_addr = mem_addr;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d, input logic exp_prot,
                           input string req);
        @(negedge clk);
        prog_req = 1'b1; req_addr = a; req_data = d;
        @(negedge clk);
        prog_req = 1'b0;
        chk(busy == 1'b1, req, "busy during program", busy, 1);
        chk(prot_err == exp_prot, req, "prot_err", prot_err, exp_prot);
        @(negedge clk);
        chk(busy == 1'b0, req, "busy after program", busy, 0);
    endtask

    task automatic do_erase(input logic [7:0] code, input logic [AW-1:0] a, input bit poke,
                            output int cycles, output logic cap_seen);
        int n;
        @(negedge clk);
        erase_req = 1'b1; erase_code = code; req_addr = a;
        wr_cnt = 0; order_bad = 0;
        @(negedge clk);
        erase_req = 1'b0;
        cap_seen = cap_err;
        n = 0;
        while (busy && n < 70000) begin
            n++;
            if (poke && n == 10) begin
                prog_req = 1'b1; req_addr = 16'h3FFF; req_data = 8'h00;
            end
            if (n == 11) prog_req = 1'b0;
            @(negedge clk);
        end
        prog_req = 1'b0;
        cycles = n;
    endtask

    // {eeprom, addr[15:0], data, expected stored byte, expected warn}
    localparam logic [33:0] PROG_TBL [8] = '{
        {1'b0, 16'h0010, 8'hA5, 8'hA5, 1'b0},
        {1'b1, 16'h0010, 8'hF0, 8'hF0, 1'b0},
        {1'b0, 16'h0123, 8'h00, 8'h00, 1'b0},
        {1'b1, 16'h0123, 8'h81, 8'h81, 1'b0},
        {1'b0, 16'h0010, 8'h3C, 8'h30, 1'b1},
        {1'b0, 16'h0010, 8'h10, 8'h10, 1'b1},
        {1'b0, 16'h0123, 8'hFF, 8'h81, 1'b1},
        {1'b0, 16'h1FFF, 8'h7E, 8'h7E, 1'b1}
    };

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        summary();
        $finish;
    end

    initial begin
        int    cyc;
        logic  capf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11", "busy", busy, 0);
        chk(prot_err == 1'b0 && cap_err == 1'b0, "R11", "error flags", {prot_err, cap_err}, 0);
        chk(warn == 1'b0, "R11", "warn", warn, 0);
        chk(any_access == 0, "R11", "array accesses", any_access, 0);

        // R1 R2 R3: program table
        for (int i = 0; i < 8; i++) begin
            logic [33:0] e;
            e = PROG_TBL[i];
            eeprom_mode = e[33];
            do_prog(e[32:17], e[16:9], 1'b0, e[33] ? "R2" : "R1");
            chk(rd(int'(e[32:17])) == e[8:1], e[33] ? "R2" : "R1", "stored byte",
                rd(int'(e[32:17])), e[8:1]);
            chk(warn == e[0], "R3", "warn after program", warn, e[0]);
        end
        eeprom_mode = 1'b0;

        @(negedge clk); warn_clr = 1'b1;
        @(negedge clk); warn_clr = 1'b0;
        chk(warn == 1'b0, "R3", "warn after clear", warn, 0);

        // R4: program without write enable
        wr_en = 1'b0;
        do_prog(16'h0050, 8'h5A, 1'b1, "R4");
        chk(rd(16'h0050) == 8'h5A, "R4", "write applied", rd(16'h0050), 8'h5A);
        wr_en = 1'b1;

        // markers
        do_prog(16'h0FFF, 8'h00, 1'b0, "R5");
        do_prog(16'h1234, 8'h00, 1'b0, "R5");
        do_prog(16'h2000, 8'h11, 1'b0, "R5");
        do_prog(16'h3000, 8'h22, 1'b0, "R5");
        do_prog(16'h3FFF, 8'h33, 1'b0, "R9");
        do_prog(16'h7FFF, 8'h00, 1'b0, "R5");
        do_prog(16'h8000, 8'h00, 1'b0, "R5");

        // R5 R6: 4 KiB at unaligned address
        do_erase(8'h20, 16'h1234, 1'b0, cyc, capf);
        chk(cyc == 4096, "R6", "busy cycles 0x20", cyc, 4096);
        chk(wr_cnt == 4096, "R6", "writes 0x20", wr_cnt, 4096);
        chk(order_bad == 0, "R6", "write order", order_bad, 0);
        chk(capf == 1'b0, "R8", "cap_err for enabled size", capf, 0);
        chk(rd(16'h1234) == 8'hFF && rd(16'h1FFF) == 8'hFF, "R5", "region erased",
            rd(16'h1FFF), 8'hFF);
        chk(rd(16'h0FFF) == 8'h00, "R5", "byte below region", rd(16'h0FFF), 8'h00);

        do_erase(8'h21, 16'h2005, 1'b0, cyc, capf);
        chk(wr_cnt == 4096, "R5", "writes 0x21", wr_cnt, 4096);
        chk(rd(16'h2000) == 8'hFF, "R5", "0x21 aligned start", rd(16'h2000), 8'hFF);
        chk(rd(16'h3000) == 8'h22, "R5", "0x21 byte above", rd(16'h3000), 8'h22);

        // R7: erase without write enable
        wr_en = 1'b0;
        do_erase(8'h20, 16'h0000, 1'b0, cyc, capf);
        @(negedge clk);
        wr_en = 1'b1;
        chk(cyc == 0, "R7", "busy for dropped erase", cyc, 0);
        chk(wr_cnt == 0, "R7", "writes for dropped erase", wr_cnt, 0);
        chk(rd(16'h0FFF) == 8'h00, "R7", "array unchanged", rd(16'h0FFF), 8'h00);

        // R10: unknown code
        do_erase(8'h99, 16'h0000, 1'b0, cyc, capf);
        @(negedge clk);
        chk(cyc == 0 && wr_cnt == 0, "R10", "unknown code activity", cyc + wr_cnt, 0);

        // R8: disabled 32 KiB size
        do_erase(8'h52, 16'h9ABC, 1'b0, cyc, capf);
        chk(capf == 1'b1, "R8", "cap_err for disabled size", capf, 1);
        chk(wr_cnt == 32768 && cyc == 32768, "R8", "erase still runs", wr_cnt, 32768);
        chk(rd(16'h8000) == 8'hFF, "R5", "0x52 region start", rd(16'h8000), 8'hFF);
        chk(rd(16'h7FFF) == 8'h00, "R5", "0x52 byte below", rd(16'h7FFF), 8'h00);

        // R5 sector, R9 program injected while busy
        do_erase(8'hD8, 16'h5555, 1'b1, cyc, capf);
        chk(wr_cnt == 16384 && cyc == 16384, "R5", "sector writes", wr_cnt, 16384);
        chk(rd(16'h4000) == 8'hFF && rd(16'h7FFF) == 8'hFF, "R5", "sector erased",
            rd(16'h7FFF), 8'hFF);
        chk(rd(16'h3FFF) == 8'h33, "R9", "program while busy ignored", rd(16'h3FFF), 8'h33);

        // R5 whole array
        do_erase(8'hC7, 16'h1234, 1'b0, cyc, capf);
        chk(wr_cnt == 65536 && cyc == 65536, "R5", "bulk writes", wr_cnt, 65536);
        chk(order_bad == 0, "R6", "bulk order", order_bad, 0);
        chk(rd(16'h0FFF) == 8'hFF && rd(16'h3FFF) == 8'hFF && rd(16'h0050) == 8'hFF,
            "R5", "bulk erased", rd(16'h3FFF), 8'hFF);

        summary();
        $finish;
    end

endmodule